// File: doc/BRIEF.md
# Serial Transmitter Self-Test Pattern Generator

This block stands between the byte-side logic and the line encoder of a serial transmitter. When its active-low test input is high, it registers the caller's byte, special-character flag and violation request and passes them on. When the test input is driven low, it first sends a fixed alternating line word, `1010101010`, every byte period. The alternating word is flagged as raw, so the encoder sends it unchanged. Driving either of two active-low enable inputs low then starts a repeating pseudo-random run of symbols.

An 8-bit maximal-length LFSR produces the run. Most states are emitted as plain data bytes. One state is replaced by a deliberate code violation, so the receiver's violation detector sees activity on every pass. A second state is replaced by a special character. An active-low loop marker drops for one cycle on the last symbol of each 255-symbol pass, so external logic can count passes.

If both enables are released while test mode stays on, the block returns to the alternating word and keeps the LFSR where it stopped. Returning the test input high restores pass-through and reloads the seed for the next test session.

Top module: `tx_bist_gen`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `sym_o` is 0, `raw_o` is 0, `viol_o` is 0 and `loop_n_o` is 1. The LFSR is loaded with the seed 0xFF.
- R2: While `test_n` is high, each edge registers `sym_o[7:0]` = `data_i`, `sym_o[8]` = `special_i`, `sym_o[9]` = 0, `viol_o` = `viol_i`, `raw_o` = 0 and `loop_n_o` = 1. The levels of `en_a_n` and `en_b_n` have no effect.
- R3: While `test_n` is low and both enables are high, each edge registers `sym_o` = 10'b1010101010, `raw_o` = 1, `viol_o` = 0 and `loop_n_o` = 1.
- R4: While `test_n` is low and an enable is low, each edge emits the current LFSR state S as data and then advances the LFSR. A data symbol has `sym_o[7:0]` = S, `sym_o[8]` = 0, `raw_o` = 0 and `viol_o` = 0. The next state is {S[6:0], S[7]^S[5]^S[4]^S[3]}, which is the polynomial x^8+x^6+x^5+x^4+1, and the first state after the seed is loaded is 0xFF.
- R5: `en_a_n` low alone and `en_b_n` low alone each run the sequence in the same way.
- R6: The state 0x01 is emitted as a violation: `viol_o` = 1, `sym_o` = 0 and `raw_o` = 0.
- R7: The state 0x7F is emitted as a special character: `sym_o[8]` = 1 and `sym_o[7:0]` = 0xBC.
- R8: `loop_n_o` is low for exactly one cycle, on the symbol of the state whose successor is the seed (0x7F). This happens once per 255 sequence symbols.
- R9: Releasing both enables while `test_n` stays low holds the LFSR. A later enable continues from the held state.
- R10: Any cycle with `test_n` high reloads the seed, so the next sequence starts again at 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| test_n | input | 1 | Self-test request, active low |
| en_a_n | input | 1 | First enable, active low |
| en_b_n | input | 1 | Second enable, active low |
| data_i | input | 8 | Pass-through data byte |
| special_i | input | 1 | Pass-through special-character flag |
| viol_i | input | 1 | Pass-through violation request |
| sym_o | output | 10 | Transmit symbol: raw line word, or {0, special flag, byte} |
| raw_o | output | 1 | `sym_o` is a literal 10-bit line word |
| viol_o | output | 1 | Encoder is to send a code violation |
| loop_n_o | output | 1 | Pass marker, active low, one cycle |

## Verification
The loop marker and the special-character substitution fall on the same symbol, state 0x7F. The bench runs the enable long enough to cross two pass boundaries and requires that symbol to carry `loop_n_o` low together with the special flag and code 0xBC. A second coincidence is provoked by releasing the enables right after the wrap symbol. The hold then has to keep the freshly reloaded seed, so the next enable must resume at 0xFF. A reference model in the bench predicts every cycle, and a monitor compares those predictions with the outputs one edge later.

// File: rtl/tx_bist_pkg.sv
package tx_bist_pkg;

   typedef enum logic [1:0] {
      MODE_PASS = 2'd0,
      MODE_ALT  = 2'd1,
      MODE_SEQ  = 2'd2
   } bist_mode_e;

   typedef enum logic {
      LFSR_FIB = 1'b0,
      LFSR_GAL = 1'b1
   } lfsr_form_e;

   // alternating line word: odd bit positions set (MSB first for even widths)
   function automatic logic [31:0] alt_word(input int unsigned width);
      logic [31:0] w;
      w = '0;
      for (int unsigned i = 0; i < width; i++) begin
         w[i] = i[0];
      end
      return w;
   endfunction

endpackage

// File: rtl/tx_bist_mode_dec.sv
module tx_bist_mode_dec #(
   parameter int unsigned NUM_EN = 2
) (
   input  logic                     test_n,
   input  logic [NUM_EN-1:0]        en_n,
   output tx_bist_pkg::bist_mode_e  mode_o
);
   import tx_bist_pkg::*;

   if (NUM_EN < 1) begin : g_bad_en
      $error("tx_bist_mode_dec: NUM_EN must be at least 1");
   end

   logic any_en;
   assign any_en = ~(&en_n);

   always_comb begin
      if (test_n)      mode_o = MODE_PASS;
      else if (any_en) mode_o = MODE_SEQ;
      else             mode_o = MODE_ALT;
   end

endmodule

// File: rtl/tx_bist_lfsr.sv
module tx_bist_lfsr #(
   parameter int unsigned            W     = 8,
   parameter logic [W-1:0]           TAPS  = 8'hB8,
   parameter logic [W-1:0]           SEED  = 8'hFF,
   parameter tx_bist_pkg::lfsr_form_e FORM = tx_bist_pkg::LFSR_FIB
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         reseed,
   input  logic         step,
   output logic [W-1:0] state_o,
   output logic         wrap_o
);
   import tx_bist_pkg::*;

   if (W < 3) begin : g_bad_w
      $error("tx_bist_lfsr: W must be at least 3");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("tx_bist_lfsr: SEED must be non-zero");
   end
   if (TAPS[W-1] != 1'b1) begin : g_bad_taps
      $error("tx_bist_lfsr: TAPS must include the top stage");
   end

   logic [W-1:0] cur_q;
   logic [W-1:0] nxt;

   if (FORM == LFSR_FIB) begin : g_fib
      always_comb nxt = {cur_q[W-2:0], ^(cur_q & TAPS)};
   end else begin : g_gal
      always_comb nxt = cur_q[0] ? ((cur_q >> 1) ^ TAPS) : (cur_q >> 1);
   end

   always_ff @(posedge clk) begin
      if (rst || reseed) cur_q <= SEED;
      else if (step)     cur_q <= nxt;
   end

   assign state_o = cur_q;
   assign wrap_o  = (nxt == SEED);

   // R4: a maximal-length register never reaches the all-zero lock-up state
   a_r4_nonzero: assert property (@(posedge clk) disable iff (rst)
      cur_q != '0);

   // R8: stepping on the wrap flag lands on the seed
   a_r8_wrap_lands_seed: assert property (@(posedge clk) disable iff (rst)
      (step && wrap_o && !reseed) |=> (cur_q == SEED));

   // R9: no step and no reseed keeps the state
   a_r9_hold_state: assert property (@(posedge clk) disable iff (rst)
      (!step && !reseed) |=> $stable(cur_q));

endmodule

// File: rtl/tx_bist_symmap.sv
module tx_bist_symmap #(
   parameter int unsigned  W             = 8,
   parameter int unsigned  SYM_W         = 10,
   parameter logic [W-1:0] VIOL_STATE    = 8'h01,
   parameter logic [W-1:0] SPECIAL_STATE = 8'h7F,
   parameter logic [W-1:0] SPECIAL_CODE  = 8'hBC
) (
   input  tx_bist_pkg::bist_mode_e mode_i,
   input  logic [W-1:0]            state_i,
   input  logic [W-1:0]            data_i,
   input  logic                    special_i,
   input  logic                    viol_i,
   output logic [SYM_W-1:0]        sym_o,
   output logic                    raw_o,
   output logic                    viol_o
);
   import tx_bist_pkg::*;

   localparam int unsigned SPECIAL_BIT = W;
   localparam logic [31:0] ALT_FULL    = alt_word(SYM_W);
   localparam logic [SYM_W-1:0] ALT_SYM = ALT_FULL[SYM_W-1:0];

   if (SYM_W < W + 2) begin : g_bad_sym
      $error("tx_bist_symmap: SYM_W must be at least W+2");
   end
   if (SYM_W > 32) begin : g_bad_sym_max
      $error("tx_bist_symmap: SYM_W must not exceed 32");
   end
   if (VIOL_STATE == SPECIAL_STATE) begin : g_bad_states
      $error("tx_bist_symmap: violation and special states must differ");
   end

   always_comb begin
      sym_o  = '0;
      raw_o  = 1'b0;
      viol_o = 1'b0;
      unique case (mode_i)
         MODE_PASS: begin
            sym_o[W-1:0]       = data_i;
            sym_o[SPECIAL_BIT] = special_i;
            viol_o             = viol_i;
         end
         MODE_ALT: begin
            sym_o = ALT_SYM;
            raw_o = 1'b1;
         end
         MODE_SEQ: begin
            if (state_i == VIOL_STATE) begin
               viol_o = 1'b1;
            end else if (state_i == SPECIAL_STATE) begin
               sym_o[W-1:0]       = SPECIAL_CODE;
               sym_o[SPECIAL_BIT] = 1'b1;
            end else begin
               sym_o[W-1:0] = state_i;
            end
         end
         default: begin
            sym_o = '0;
         end
      endcase
   end

endmodule

// File: rtl/tx_bist_gen.sv
module tx_bist_gen #(
   parameter int unsigned           DATA_W        = 8,
   parameter int unsigned           SYM_W         = 10,
   parameter logic [DATA_W-1:0]     LFSR_TAPS     = 8'hB8,
   parameter logic [DATA_W-1:0]     LFSR_SEED     = 8'hFF,
   parameter logic [DATA_W-1:0]     VIOL_STATE    = 8'h01,
   parameter logic [DATA_W-1:0]     SPECIAL_STATE = 8'h7F,
   parameter logic [DATA_W-1:0]     SPECIAL_CODE  = 8'hBC,
   parameter tx_bist_pkg::lfsr_form_e LFSR_FORM   = tx_bist_pkg::LFSR_FIB
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              test_n,
   input  logic              en_a_n,
   input  logic              en_b_n,
   input  logic [DATA_W-1:0] data_i,
   input  logic              special_i,
   input  logic              viol_i,
   output logic [SYM_W-1:0]  sym_o,
   output logic              raw_o,
   output logic              viol_o,
   output logic              loop_n_o
);
   import tx_bist_pkg::*;

   localparam int unsigned NUM_EN = 2;
   localparam int unsigned PERIOD = (1 << DATA_W) - 1;
   localparam logic [31:0] ALT_FULL = alt_word(SYM_W);
   localparam logic [SYM_W-1:0] ALT_SYM = ALT_FULL[SYM_W-1:0];

   bist_mode_e        mode;
   logic [DATA_W-1:0] lfsr_state;
   logic              lfsr_wrap;
   logic              reseed;
   logic              step;
   logic [SYM_W-1:0]  sym_d;
   logic              raw_d;
   logic              viol_d;
   logic              loop_n_d;

   tx_bist_mode_dec #(
      .NUM_EN (NUM_EN)
   ) u_mode (
      .test_n (test_n),
      .en_n   ({en_b_n, en_a_n}),
      .mode_o (mode)
   );

   assign reseed = (mode == MODE_PASS);
   assign step   = (mode == MODE_SEQ);

   tx_bist_lfsr #(
      .W    (DATA_W),
      .TAPS (LFSR_TAPS),
      .SEED (LFSR_SEED),
      .FORM (LFSR_FORM)
   ) u_lfsr (
      .clk     (clk),
      .rst     (rst),
      .reseed  (reseed),
      .step    (step),
      .state_o (lfsr_state),
      .wrap_o  (lfsr_wrap)
   );

   tx_bist_symmap #(
      .W             (DATA_W),
      .SYM_W         (SYM_W),
      .VIOL_STATE    (VIOL_STATE),
      .SPECIAL_STATE (SPECIAL_STATE),
      .SPECIAL_CODE  (SPECIAL_CODE)
   ) u_map (
      .mode_i    (mode),
      .state_i   (lfsr_state),
      .data_i    (data_i),
      .special_i (special_i),
      .viol_i    (viol_i),
      .sym_o     (sym_d),
      .raw_o     (raw_d),
      .viol_o    (viol_d)
   );

   assign loop_n_d = !(step && lfsr_wrap);

   always_ff @(posedge clk) begin
      if (rst) begin
         sym_o    <= '0;
         raw_o    <= 1'b0;
         viol_o   <= 1'b0;
         loop_n_o <= 1'b1;
      end else begin
         sym_o    <= sym_d;
         raw_o    <= raw_d;
         viol_o   <= viol_d;
         loop_n_o <= loop_n_d;
      end
   end

   // symbols stepped since the seed was last loaded (checks pass length)
   logic [DATA_W-1:0] pass_cnt;
   always_ff @(posedge clk) begin
      if (rst || reseed)            pass_cnt <= '0;
      else if (step && lfsr_wrap)   pass_cnt <= '0;
      else if (step)                pass_cnt <= pass_cnt + 1'b1;
   end

   // R8: the wrap arrives after exactly PERIOD-1 earlier symbols of the pass
   a_r8_pass_length: assert property (@(posedge clk) disable iff (rst)
      (step && lfsr_wrap) |-> (pass_cnt == DATA_W'(PERIOD - 1)));

   // R8: marker lasts one cycle
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
      !loop_n_o |=> loop_n_o);

   // R3: a raw word is always the alternating pattern and carries no flags
   a_r3_alt_word: assert property (@(posedge clk) disable iff (rst)
      raw_o |-> (sym_o == ALT_SYM && !viol_o && loop_n_o));

   // R6: a violation never rides on a raw word or a nonzero symbol in test
   a_r6_viol_clean: assert property (@(posedge clk) disable iff (rst)
      (viol_o && !$past(test_n)) |-> (sym_o == '0 && !raw_o));

endmodule

// File: tb/tb_tx_bist_gen.sv
module tb_tx_bist_gen;

   logic       clk;
   logic       rst;
   logic       test_n;
   logic       en_a_n;
   logic       en_b_n;
   logic [7:0] data_i;
   logic       special_i;
   logic       viol_i;
   logic [9:0] sym_o;
   logic       raw_o;
   logic       viol_o;
   logic       loop_n_o;

   tx_bist_gen dut (
      .clk       (clk),
      .rst       (rst),
      .test_n    (test_n),
      .en_a_n    (en_a_n),
      .en_b_n    (en_b_n),
      .data_i    (data_i),
      .special_i (special_i),
      .viol_i    (viol_i),
      .sym_o     (sym_o),
      .raw_o     (raw_o),
      .viol_o    (viol_o),
      .loop_n_o  (loop_n_o)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   int checks   = 0;
   int failures = 0;
   int exp_pulses = 0;
   int got_pulses = 0;
   bit finished = 1'b0;

   typedef struct packed {
      logic [9:0] sym;
      logic       raw;
      logic       viol;
      logic       loopn;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   logic [7:0] m_state;

   function automatic logic [7:0] lfsr_next(input logic [7:0] s);
      return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // driver: apply inputs at the falling edge and predict the next output
   task automatic drive(input logic t_n, input logic a_n, input logic b_n,
                        input logic [7:0] d, input logic sp, input logic vi,
                        input string tag);
      exp_t  e;
      string tg;
      @(negedge clk);
      test_n = t_n; en_a_n = a_n; en_b_n = b_n;
      data_i = d; special_i = sp; viol_i = vi;
      e = '{sym: 10'h0, raw: 1'b0, viol: 1'b0, loopn: 1'b1};
      tg = tag;
      if (t_n) begin
         e.sym  = {1'b0, sp, d};
         e.viol = vi;
         m_state = 8'hFF;
      end else if (a_n && b_n) begin
         e.sym = 10'b1010101010;
         e.raw = 1'b1;
      end else begin
         if (m_state == 8'h01) begin
            e.viol = 1'b1;
            tg = {tag, " R6"};
         end else if (m_state == 8'h7F) begin
            e.sym = {2'b01, 8'hBC};
            tg = {tag, " R7"};
         end else begin
            e.sym = {2'b00, m_state};
         end
         if (lfsr_next(m_state) == 8'hFF) begin
            e.loopn = 1'b0;
            exp_pulses++;
            tg = {tg, " R8"};
         end
         m_state = lfsr_next(m_state);
      end
      exp_q.push_back(e);
      tag_q.push_back(tg);
   endtask

   // monitor: compare one edge after each drive
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (!loop_n_o && !rst) got_pulses++;
         if (exp_q.size() > 0) begin
            exp_t  e;
            string tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            check({sym_o, raw_o, viol_o, loop_n_o} == e, tg, "sym/raw/viol/loop_n",
                  {19'b0, sym_o, raw_o, viol_o, loop_n_o}, {19'b0, e});
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; test_n = 1'b0; en_a_n = 1'b0; en_b_n = 1'b1;
      data_i = 8'h5A; special_i = 1'b1; viol_i = 1'b1;
      m_state = 8'hFF;
      repeat (3) @(posedge clk);
      #2;
      // R1: reset values even with test and enable requested
      check(sym_o == 10'h0 && !raw_o && !viol_o && loop_n_o, "R1", "reset outputs",
            {20'b0, sym_o, raw_o, viol_o}, 32'h0);
      @(negedge clk);
      rst = 1'b0; test_n = 1'b1; en_a_n = 1'b1;
      @(negedge clk);
      // R1: seed loaded at reset, proven by first sequence symbol later

      // R2: pass-through, enables toggled
      drive(1, 1, 1, 8'h3C, 0, 0, "R2");
      drive(1, 0, 1, 8'hC3, 1, 0, "R2");
      drive(1, 1, 0, 8'h00, 0, 1, "R2");
      drive(1, 0, 0, 8'hFF, 1, 1, "R2");
      drive(1, 1, 1, 8'h81, 0, 0, "R2");

      // R3: alternating word
      repeat (4) drive(0, 1, 1, 8'hAA, 1, 1, "R3");

      // R4 R5: enable A alone
      for (int i = 0; i < 20; i++) drive(0, 0, 1, 8'h11, 0, 1, "R4 R5 en_a");

      // R9: hold while both enables released
      repeat (3) drive(0, 1, 1, 8'h22, 0, 0, "R9 hold");
      for (int i = 0; i < 5; i++) drive(0, 1, 0, 8'h33, 0, 0, "R9 resume R5 en_b");

      // R5 R6 R7 R8: run through a pass boundary on enable B
      while (m_state != 8'h7F) drive(0, 1, 0, 8'h44, 0, 0, "R5 R4");
      drive(0, 1, 0, 8'h44, 0, 0, "R5 wrap");
      // R9 R8: release right after the wrap, seed must be held
      repeat (2) drive(0, 1, 1, 8'h55, 0, 0, "R9 after wrap");
      for (int i = 0; i < 300; i++) drive(0, 0, 0, 8'h66, 0, 0, "R4 R5 both");

      // R10: leave test, re-enter, must restart at seed
      repeat (2) drive(1, 0, 0, 8'h77, 0, 0, "R10 pass");
      for (int i = 0; i < 6; i++) drive(0, 0, 1, 8'h88, 0, 0, "R10 restart");
      repeat (2) drive(1, 1, 1, 8'h99, 1, 0, "R2 resume");

      @(posedge clk);
      @(posedge clk);
      #3;
      check(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 0);
      // R8: one pulse per completed pass
      check(got_pulses == exp_pulses && exp_pulses >= 2, "R8", "loop pulse count",
            got_pulses, exp_pulses);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule